// File: doc/BRIEF.md
# Watermark FIFO Mailbox Channel

This block carries 32-bit words from a sending agent to a receiving agent through a 32-entry first-in first-out queue. Both sides reach it through one register port. A write to the push register appends a word. A read of the pop register returns the oldest word and removes it in the same access. A status register shows the fill condition against a programmable watermark, and sticky error flags record a dropped push and a pop from an empty queue.

Changes in the fill level are recorded as pending event bits in a shared event register. These include becoming full, becoming empty, becoming non-empty, rising through the watermark and falling back below it, overflow and underflow. Each side has its own enable mask. The sending side enables the events it cares about, usually empty and overflow. The receiving side usually enables the rising watermark crossing, full and underflow. Each side gets an interrupt line that is the OR of its enabled pending bits. Software clears pending bits by writing ones. A flush register empties the queue without touching the watermark.

Top module: `wmf_mailbox`

## Requirements
- R1: Words leave the pop register (0xB0) in the order they were written to the push register (0xAC). The fill level never exceeds 32.
- R2: The status register (0xB4) shows the following bits, with all other bits reading zero:
  - bit 0 is set when the fill level is at or above the watermark;
  - bit 1 is set when the queue holds 32 words;
  - bit 2 is set when the queue holds no words.
  After reset it reads 0x4.
- R3: A push to a full queue is discarded. It sets sticky status bit 4 and pending event bit 6. Words already stored stay intact.
- R4: A pop from an empty queue returns zero. It sets sticky status bit 3 and pending event bit 7.
- R5: The queue-condition events fire only on the access that enters the condition, never while it merely persists:
  - bit 2 on entering full;
  - bit 3 on entering empty;
  - bit 8 on entering non-empty.
- R6: Pending bit 4 is set when the fill level moves from below the watermark to at or above it. Pending bit 5 is set on the reverse move.
- R7: The pending event register reads at 0xC8. Writing a one to a bit of 0xC4 clears that pending bit, and bits written as zero are left unchanged.
- R8: The sender enable mask is at 0xBC and the receiver enable mask at 0xC0. Each interrupt output is high exactly when some pending bit is enabled in its mask.
- R9: Writing bit 0 of 0xCC empties the queue and clears sticky status bits 3 and 4. The watermark keeps its value, and 0xCC always reads zero.
- R10: The watermark register (0xB8) resets to 32. It is readable and writable, and a written value above 32 is stored as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops when addressing 0xB0) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the access cycle |
| irq_snd | output | 1 | Sender-side interrupt |
| irq_rcv | output | 1 | Receiver-side interrupt |

## Verification
A wrong pointer or level register shows up at the pop register on the very next read, as a word out of order or a zero where data was expected. A wrong level also shows in the full, empty and watermark status bits, in the cycle after the access that caused the error. A faulty edge detector sets or misses a pending event bit, and this is visible in the event register and on the enabled interrupt line one cycle after the offending push or pop. That is why the bench reads status and pending bits after each step rather than only at the end of a sequence.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

    // register byte addresses
    localparam logic [7:0] A_PUSH   = 8'hAC;
    localparam logic [7:0] A_POP    = 8'hB0;
    localparam logic [7:0] A_STAT   = 8'hB4;
    localparam logic [7:0] A_WMARK  = 8'hB8;
    localparam logic [7:0] A_EN_SND = 8'hBC;
    localparam logic [7:0] A_EN_RCV = 8'hC0;
    localparam logic [7:0] A_ICLR   = 8'hC4;
    localparam logic [7:0] A_IPEND  = 8'hC8;
    localparam logic [7:0] A_FLUSH  = 8'hCC;

    // pending event bit positions
    localparam int EV_FULL   = 2;
    localparam int EV_EMPTY  = 3;
    localparam int EV_WM_UP  = 4;
    localparam int EV_WM_DN  = 5;
    localparam int EV_OVF    = 6;
    localparam int EV_UDF    = 7;
    localparam int EV_NEMPTY = 8;
    localparam int EV_W      = 9;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_op_t;

endpackage

// File: rtl/wmf_store.sv
module wmf_store
    import wmf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_op_t         op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level_q,
    output logic [LVL_W-1:0] level_d,
    output logic             full,
    output logic             empty,
    output logic             drop,
    output logic             miss
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [LVL_W-1:0]            lvl;
    } store_t;

    store_t st_d, st_q;
    logic [PTR_W-1:0] wp_inc, rp_inc;

    generate
        if (DEPTH == (1 << PTR_W)) begin : g_pow2
            assign wp_inc = st_q.wp + 1'b1;
            assign rp_inc = st_q.rp + 1'b1;
        end else begin : g_wrap
            assign wp_inc = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            assign rp_inc = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
    endgenerate

    assign full    = (st_q.lvl == LVL_W'(DEPTH));
    assign empty   = (st_q.lvl == '0);
    assign drop    = op.push && full && !op.flush;
    assign miss    = op.pop && empty && !op.flush;
    assign head    = empty ? '0 : st_q.mem[st_q.rp];
    assign level_q = st_q.lvl;
    assign level_d = st_d.lvl;

    always_comb begin
        st_d = st_q;
        if (op.flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else if (op.push && !full) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = wp_inc;
            st_d.lvl          = st_q.lvl + 1'b1;
        end else if (op.pop && !empty) begin
            st_d.rp  = rp_inc;
            st_d.lvl = st_q.lvl - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level_q <= LVL_W'(DEPTH)); // R1
    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n) (op.push && full && !op.flush) |=> full); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) op.flush |=> empty); // R9

endmodule

// File: rtl/wmf_events.sv
module wmf_events
    import wmf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_q,
    input  logic [LVL_W-1:0] lvl_d,
    input  logic [LVL_W-1:0] wm,
    input  logic             drop,
    input  logic             miss,
    input  logic             flush,
    input  logic [EV_W-1:0]  clr,
    output logic [EV_W-1:0]  pend,
    output logic             ovf_st,
    output logic             udf_st
);

    typedef struct packed {
        logic [EV_W-1:0] pend;
        logic            ovf;
        logic            udf;
    } ev_t;

    ev_t ev_d, ev_q;
    logic [EV_W-1:0] set;

    always_comb begin
        set            = '0;
        set[EV_FULL]   = (lvl_d == LVL_W'(DEPTH)) && (lvl_q != LVL_W'(DEPTH));
        set[EV_EMPTY]  = (lvl_d == '0) && (lvl_q != '0);
        set[EV_NEMPTY] = (lvl_q == '0) && (lvl_d != '0);
        set[EV_WM_UP]  = (lvl_q < wm) && (lvl_d >= wm);
        set[EV_WM_DN]  = (lvl_q >= wm) && (lvl_d < wm);
        set[EV_OVF]    = drop;
        set[EV_UDF]    = miss;

        ev_d      = ev_q;
        ev_d.pend = (ev_q.pend & ~clr) | set;
        ev_d.ovf  = flush ? 1'b0 : (ev_q.ovf | drop);
        ev_d.udf  = flush ? 1'b0 : (ev_q.udf | miss);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign pend   = ev_q.pend;
    assign ovf_st = ev_q.ovf;
    assign udf_st = ev_q.udf;

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (udf_st && !flush) |=> udf_st); // R4
    AST_EMPTY_EVT: assert property (@(posedge clk) disable iff (!rst_n) (lvl_q != '0 && lvl_d == '0) |=> pend[EV_EMPTY]); // R5
    AST_WM_UP_EVT: assert property (@(posedge clk) disable iff (!rst_n) (lvl_q < wm && lvl_d >= wm) |=> pend[EV_WM_UP]); // R6
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n) (clr[EV_NEMPTY] && !(lvl_q == '0 && lvl_d != '0)) |=> !pend[EV_NEMPTY]); // R7

endmodule

// File: rtl/wmf_mailbox.sv
module wmf_mailbox
    import wmf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_snd,
    output logic        irq_rcv
);

    typedef struct packed {
        logic [LVL_W-1:0] wm;
        logic [EV_W-1:0]  en_snd;
        logic [EV_W-1:0]  en_rcv;
    } regs_t;

    regs_t rg_d, rg_q;
    fifo_op_t op;
    logic [EV_W-1:0]  clr, pend;
    logic [WIDTH-1:0] head;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic full, empty, drop, miss, ovf_st, udf_st;

    always_comb begin
        op.push  = bus_wr && (bus_addr == A_PUSH);
        op.pop   = bus_rd && (bus_addr == A_POP);
        op.flush = bus_wr && (bus_addr == A_FLUSH) && bus_wdata[0];
        clr      = (bus_wr && bus_addr == A_ICLR) ? bus_wdata[EV_W-1:0] : '0;
    end

    wmf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata[WIDTH-1:0]),
        .head(head), .level_q(lvl_q), .level_d(lvl_d),
        .full(full), .empty(empty), .drop(drop), .miss(miss)
    );

    wmf_events #(.DEPTH(DEPTH)) u_events (
        .clk(clk), .rst_n(rst_n), .lvl_q(lvl_q), .lvl_d(lvl_d), .wm(rg_q.wm),
        .drop(drop), .miss(miss), .flush(op.flush), .clr(clr),
        .pend(pend), .ovf_st(ovf_st), .udf_st(udf_st)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_wr) begin
            unique case (bus_addr)
                A_WMARK:  rg_d.wm = (bus_wdata > 32'(DEPTH)) ? LVL_W'(DEPTH)
                                                             : bus_wdata[LVL_W-1:0];
                A_EN_SND: rg_d.en_snd = bus_wdata[EV_W-1:0];
                A_EN_RCV: rg_d.en_rcv = bus_wdata[EV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.wm     <= LVL_W'(DEPTH);
            rg_q.en_snd <= '0;
            rg_q.en_rcv <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_POP:    bus_rdata = 32'(head);
            A_STAT:   bus_rdata = {27'd0, ovf_st, udf_st, empty, full, (lvl_q >= rg_q.wm)};
            A_WMARK:  bus_rdata = 32'(rg_q.wm);
            A_EN_SND: bus_rdata = 32'(rg_q.en_snd);
            A_EN_RCV: bus_rdata = 32'(rg_q.en_rcv);
            A_IPEND:  bus_rdata = 32'(pend);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_snd = |(pend & rg_q.en_snd);
    assign irq_rcv = |(pend & rg_q.en_rcv);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (pend == '0) |-> (!irq_snd && !irq_rcv)); // R8
    AST_WM_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (op.flush) |=> $stable(rg_q.wm)); // R9

endmodule

// File: tb/wmf_mailbox_tb.sv
module wmf_mailbox_tb_top;
    import wmf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_snd, irq_rcv;
    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    wmf_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_snd(irq_snd), .irq_rcv(irq_rcv)
    );

    // stimulus table: push (1) or pop (0), data pushed or expected, status after
    localparam int NV = 7;
    localparam logic        V_PUSH [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] V_DATA [NV] = '{32'h11111111, 32'h22222222, 32'h33333333,
                                            32'h11111111, 32'h22222222, 32'h33333333, 32'h0};
    localparam logic [31:0] V_STAT [NV] = '{32'h0, 32'h1, 32'h1, 32'h1, 32'h0, 32'h4, 32'hC};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        bus_read(A_STAT, d);  check("R2 reset status", d, 32'h4);
        bus_read(A_WMARK, d); check("R10 reset watermark", d, 32'd32);
        bus_read(A_IPEND, d); check("R7 reset pending", d, 32'h0);
        check("R8 reset irqs", {30'd0, irq_snd, irq_rcv}, 32'h0);

        // watermark saturation then program 2
        bus_write(A_WMARK, 32'd40);
        bus_read(A_WMARK, d); check("R10 watermark saturates", d, 32'd32);
        bus_write(A_WMARK, 32'd2);
        bus_read(A_WMARK, d); check("R10 watermark write", d, 32'd2);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (V_PUSH[i]) begin
                bus_write(A_PUSH, V_DATA[i]);
            end else begin
                bus_read(A_POP, d);
                check("R1 R4 pop data", d, V_DATA[i]);
            end
            bus_read(A_STAT, d);
            check("R2 status after step", d, V_STAT[i]);
        end
        // nonempty, wm up, wm down, empty, underflow
        bus_read(A_IPEND, d); check("R5 R6 pending after walk", d, 32'h1B8);

        // partial and full clear
        bus_write(A_ICLR, 32'h80);
        bus_read(A_IPEND, d); check("R7 clear one bit", d, 32'h138);
        bus_write(A_ICLR, 32'h1FF);
        bus_read(A_IPEND, d); check("R7 clear all", d, 32'h0);

        // flush while empty
        bus_write(A_FLUSH, 32'h1);
        bus_read(A_STAT, d);  check("R9 flush clears underflow", d, 32'h4);
        bus_read(A_FLUSH, d); check("R9 flush reads zero", d, 32'h0);
        bus_read(A_WMARK, d); check("R9 watermark kept", d, 32'd2);
        bus_read(A_IPEND, d); check("R5 no event on empty flush", d, 32'h0);

        // flush with content
        bus_write(A_PUSH, 32'hA);
        bus_write(A_PUSH, 32'hB);
        bus_write(A_ICLR, 32'h1FF);
        bus_write(A_FLUSH, 32'h1);
        bus_read(A_IPEND, d); check("R6 R9 flush events", d, 32'h28);
        bus_read(A_STAT, d);  check("R9 flush empties", d, 32'h4);
        bus_write(A_ICLR, 32'h1FF);

        // fill to full
        for (int i = 0; i < 32; i++) bus_write(A_PUSH, 32'h100 + 32'(i));
        bus_read(A_IPEND, d); check("R5 R6 fill events", d, 32'h114);
        bus_read(A_STAT, d);  check("R2 full status", d, 32'h3);
        bus_write(A_ICLR, 32'h1FF);

        // overflow
        bus_write(A_PUSH, 32'hDEAD);
        bus_read(A_STAT, d);  check("R3 overflow sticky", d, 32'h13);
        bus_read(A_IPEND, d); check("R3 R5 overflow only", d, 32'h40);

        // interrupt gating
        bus_write(A_EN_SND, 32'h40);
        check("R8 sender irq", {30'd0, irq_snd, irq_rcv}, 32'h2);
        bus_write(A_EN_RCV, 32'h04);
        check("R8 receiver masked", {31'd0, irq_rcv}, 32'h0);
        bus_write(A_EN_RCV, 32'h40);
        check("R8 receiver irq", {31'd0, irq_rcv}, 32'h1);
        bus_write(A_ICLR, 32'h40);
        check("R8 irqs drop after clear", {30'd0, irq_snd, irq_rcv}, 32'h0);

        // drain: order kept, dropped word absent
        for (int i = 0; i < 32; i++) begin
            bus_read(A_POP, d);
            check("R1 R3 drain order", d, 32'h100 + 32'(i));
        end
        bus_read(A_STAT, d); check("R3 overflow stays sticky", d, 32'h14);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule